// File: doc/BRIEF.md
# Two-Level Standby Power Controller

This controller sequences the low-power states of a small processor subsystem. A sleep request from the core is turned into one of three outcomes. With standby disabled it becomes a light sleep: the CPU clock stops and the oscillator keeps running. With standby enabled the subsystem parks in standby: all clocks stop, the oscillator is turned off and the I/O pins are frozen. With deep standby also enabled, the controller continues from standby into deep standby, where core power is removed as well and RAM power is kept or dropped according to a 3-bit cut code.

Wake events come from a non-maskable input and sixteen maskable interrupt lines. All of them are resynchronised and treated as levels. A wake that is pending when standby is reached cancels the deep step, whatever the deep-enable setting. The controller then restarts the oscillator and holds the CPU back for a settling time selected by a 5-bit code. At the end of that time it fires a one-cycle release pulse. Leaving deep standby is handled elsewhere; within this block only reset ends it.

Top module: `stbyPowerCtrl`

## Requirements
- R1: After reset `powerMode` reads 0 (run), the CPU and peripheral clocks run, and `oscEn`, `corePwrEn` and `ramPwrEn` are 1. `ioHold` and `wakeRelease` are 0.
- R2: A `sleepReq` in run with `stbyEn`=0 moves `powerMode` to 1 (sleep) on the next clock. In sleep the CPU clock is halted, the peripheral clock runs and `oscEn` stays 1.
- R3: In sleep, a wake ends sleep. A wake is `wakeNmi` at 1, or any `wakeIrq[i]` at 1 whose `irqEnable[i]` is 1. `wakeRelease` is then high for exactly one cycle and `powerMode` returns to 0. A masked interrupt line has no effect.
- R4: A `sleepReq` in run with `stbyEn`=1 moves `powerMode` to 2 (standby). In standby both clocks are halted, `oscEn` is 0, `ioHold` is 1 and core and RAM power stay on. The controller remains there while no wake is present and `deepEn` is 0.
- R5: In standby with `deepEn`=1 and no wake present, `powerMode` becomes 4 (deep standby) on the very next clock.
- R6: A wake present while in standby moves `powerMode` to 3 (settling) on the next clock, even when `deepEn` is 1. Deep standby is not entered.
- R7: Settling lasts 2^(`settleSel`+6) cycles, capped at 2^CNT_W-1 (65535 by default). `oscEn` is 1 throughout. `wakeRelease` is high only in the last settling cycle, after which `powerMode` is 0.
- R8: In deep standby both clocks are halted, and `oscEn` and `corePwrEn` are 0 while `ioHold` is 1. Wake inputs and sleep requests do not change the mode.
- R9: In deep standby `ramPwrEn` is 1 when `ramCut` was 3'b000 in the cycle deep standby was entered, and 0 for every other code. Later changes of `ramCut` have no effect.
- R10: Wake inputs pass through a two-flop synchroniser. A wake asserted before a clock edge produces `wakeRelease` from sleep after the second rising edge.
- R11: A `sleepReq` outside run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sleepReq | input | 1 | Sleep request strobe from the core |
| stbyEn | input | 1 | Turns a sleep request into standby |
| deepEn | input | 1 | Allows the step from standby to deep standby |
| settleSel | input | 5 | Oscillator settling-time select |
| ramCut | input | 3 | RAM power-cut code for deep standby |
| wakeNmi | input | 1 | Non-maskable wake input (level) |
| wakeIrq | input | 16 | Maskable wake inputs (level) |
| irqEnable | input | 16 | Per-line enable for wakeIrq |
| powerMode | output | 3 | 0 run, 1 sleep, 2 standby, 3 settling, 4 deep standby |
| cpuClkHalt | output | 1 | Stops the CPU clock |
| periphClkHalt | output | 1 | Stops the peripheral clocks |
| oscEn | output | 1 | Oscillator enable |
| corePwrEn | output | 1 | Core and peripheral supply enable |
| ramPwrEn | output | 1 | RAM supply enable |
| ioHold | output | 1 | Freezes I/O pin state |
| wakeRelease | output | 1 | One-cycle pulse releasing wake interrupt handling |

## Verification
The hardest case to reach is the race at the edge of standby: a wake has to be active exactly when the controller lands in standby with deep standby enabled. Otherwise the deep step happens at once and cannot be undone. The bench raises a wake line several cycles before the sleep request, so the synchroniser output is already settled. It then checks that the mode goes run, standby, settling, and never deep. The capped settling length is reached by choosing the largest select code and counting all 65535 settling cycles.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    PM_RUN    = 3'd0,
    PM_SLEEP  = 3'd1,
    PM_STBY   = 3'd2,
    PM_SETTLE = 3'd3,
    PM_DEEP   = 3'd4
  } pmode_t;

  typedef struct packed {
    logic loadSettle;  // start the settling countdown
    logic runSettle;   // countdown active this cycle
    logic latchRam;    // capture RAM cut code on deep entry
  } pstrobe_t;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int NUM_IRQ = 16,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               nmiIn,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic [NUM_IRQ-1:0] irqEnable,
  output logic               wakeAny
);
  localparam int W = NUM_IRQ + 1;

  logic [W-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= {nmiIn, irqIn};
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
      end
    end
  endgenerate

  logic               nmiSync;
  logic [NUM_IRQ-1:0] irqSync;
  assign {nmiSync, irqSync} = stage[STAGES-1];
  assign wakeAny = nmiSync | (|(irqSync & irqEnable));
endmodule

// File: rtl/pwr_ctrl.sv
module pwr_ctrl
  import pwr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sleepReq,
  input  logic     stbyEn,
  input  logic     deepEn,
  input  logic     wakeAny,
  input  logic     settleZero,
  output pmode_t   state,
  output pstrobe_t strobe,
  output logic     wakeRelease
);
  pmode_t nextState;

  always_comb begin
    nextState   = state;
    strobe      = '0;
    wakeRelease = 1'b0;
    unique case (state)
      PM_RUN: begin
        if (sleepReq) nextState = stbyEn ? PM_STBY : PM_SLEEP;
      end
      PM_SLEEP: begin
        if (wakeAny) begin
          nextState   = PM_RUN;
          wakeRelease = 1'b1;
        end
      end
      PM_STBY: begin
        if (wakeAny) begin
          nextState         = PM_SETTLE;
          strobe.loadSettle = 1'b1;
        end else if (deepEn) begin
          nextState       = PM_DEEP;
          strobe.latchRam = 1'b1;
        end
      end
      PM_SETTLE: begin
        strobe.runSettle = 1'b1;
        if (settleZero) begin
          nextState   = PM_RUN;
          wakeRelease = 1'b1;
        end
      end
      PM_DEEP: nextState = PM_DEEP;
      default: nextState = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= PM_RUN;
    else       state <= nextState;
endmodule

// File: rtl/pwr_datapath.sv
module pwr_datapath
  import pwr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SEL_W   = 5,
  parameter int BASE_SH = 6,
  parameter int CUT_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  pmode_t           state,
  input  pstrobe_t         strobe,
  input  logic [SEL_W-1:0] settleSel,
  input  logic [CUT_W-1:0] ramCut,
  output logic             settleZero,
  output logic             cpuClkHalt,
  output logic             periphClkHalt,
  output logic             oscEn,
  output logic             corePwrEn,
  output logic             ramPwrEn,
  output logic             ioHold
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] settleLen(input logic [SEL_W-1:0] sel);
    int sh;
    sh = int'(sel) + BASE_SH;
    if (sh >= CNT_W) return '1;
    else             return CNT_ONE << sh;
  endfunction

  logic [CNT_W-1:0] settleCnt;
  logic             ramKeep;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                 settleCnt <= '0;
    else if (strobe.loadSettle) settleCnt <= settleLen(settleSel) - CNT_ONE;
    else if (strobe.runSettle && settleCnt != '0) settleCnt <= settleCnt - CNT_ONE;

  assign settleZero = (settleCnt == '0);

  // Only the all-zero code keeps RAM powered; every other code cuts it.
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)               ramKeep <= 1'b1;
    else if (strobe.latchRam) ramKeep <= (ramCut == '0);

  always_comb begin
    cpuClkHalt    = 1'b0;
    periphClkHalt = 1'b0;
    oscEn         = 1'b1;
    corePwrEn     = 1'b1;
    ramPwrEn      = 1'b1;
    ioHold        = 1'b0;
    unique case (state)
      PM_RUN: ;
      PM_SLEEP: cpuClkHalt = 1'b1;
      PM_STBY: begin
        cpuClkHalt    = 1'b1;
        periphClkHalt = 1'b1;
        oscEn         = 1'b0;
        ioHold        = 1'b1;
      end
      PM_SETTLE: begin
        cpuClkHalt    = 1'b1;
        periphClkHalt = 1'b1;
        ioHold        = 1'b1;
      end
      PM_DEEP: begin
        cpuClkHalt    = 1'b1;
        periphClkHalt = 1'b1;
        oscEn         = 1'b0;
        corePwrEn     = 1'b0;
        ramPwrEn      = ramKeep;
        ioHold        = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stbyPowerCtrl.sv
module stbyPowerCtrl
  import pwr_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int CNT_W   = 16,
  parameter int SEL_W   = 5,
  parameter int CUT_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sleepReq,
  input  logic               stbyEn,
  input  logic               deepEn,
  input  logic [SEL_W-1:0]   settleSel,
  input  logic [CUT_W-1:0]   ramCut,
  input  logic               wakeNmi,
  input  logic [NUM_IRQ-1:0] wakeIrq,
  input  logic [NUM_IRQ-1:0] irqEnable,
  output logic [2:0]         powerMode,
  output logic               cpuClkHalt,
  output logic               periphClkHalt,
  output logic               oscEn,
  output logic               corePwrEn,
  output logic               ramPwrEn,
  output logic               ioHold,
  output logic               wakeRelease
);
  logic     wakeAny;
  logic     settleZero;
  pmode_t   state;
  pstrobe_t strobe;

  wake_sync #(.NUM_IRQ(NUM_IRQ), .STAGES(2)) i_sync (
    .clk(clk), .rstN(rstN), .nmiIn(wakeNmi), .irqIn(wakeIrq),
    .irqEnable(irqEnable), .wakeAny(wakeAny)
  );

  pwr_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .stbyEn(stbyEn),
    .deepEn(deepEn), .wakeAny(wakeAny), .settleZero(settleZero),
    .state(state), .strobe(strobe), .wakeRelease(wakeRelease)
  );

  pwr_datapath #(.CNT_W(CNT_W), .SEL_W(SEL_W), .CUT_W(CUT_W)) i_dp (
    .clk(clk), .rstN(rstN), .state(state), .strobe(strobe),
    .settleSel(settleSel), .ramCut(ramCut), .settleZero(settleZero),
    .cpuClkHalt(cpuClkHalt), .periphClkHalt(periphClkHalt), .oscEn(oscEn),
    .corePwrEn(corePwrEn), .ramPwrEn(ramPwrEn), .ioHold(ioHold)
  );

  assign powerMode = state;
endmodule

// File: rtl/pwr_checker.sv
module pwr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       deepEn,
  input logic       wakeAny,
  input logic [2:0] powerMode,
  input logic       wakeRelease,
  input logic       oscEn,
  input logic       corePwrEn,
  input logic       ioHold
);
  a_r4_stby_outputs: assert property (@(posedge clk) disable iff (!rstN)
    powerMode == 3'd2 |-> !oscEn && ioHold);

  a_r5_deep_step: assert property (@(posedge clk) disable iff (!rstN)
    powerMode == 3'd2 && deepEn && !wakeAny |=> powerMode == 3'd4);

  a_r6_wake_aborts_deep: assert property (@(posedge clk) disable iff (!rstN)
    powerMode == 3'd2 && wakeAny |=> powerMode == 3'd3);

  a_r7_release_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wakeRelease |=> !wakeRelease && powerMode == 3'd0);

  a_r8_deep_sticky: assert property (@(posedge clk) disable iff (!rstN)
    powerMode == 3'd4 |=> powerMode == 3'd4);

  a_r8_deep_power: assert property (@(posedge clk) disable iff (!rstN)
    powerMode == 3'd4 |-> !oscEn && !corePwrEn && ioHold);
endmodule

bind stbyPowerCtrl pwr_checker i_pwrChk (
  .clk(clk), .rstN(rstN), .deepEn(deepEn), .wakeAny(wakeAny),
  .powerMode(powerMode), .wakeRelease(wakeRelease), .oscEn(oscEn),
  .corePwrEn(corePwrEn), .ioHold(ioHold)
);

// File: tb/test_stbyPowerCtrl.sv
`timescale 1ns/1ps
module test_stbyPowerCtrl;
  logic        clk = 1'b0;
  logic        rstN;
  logic        sleepReq, stbyEn, deepEn, wakeNmi;
  logic [4:0]  settleSel;
  logic [2:0]  ramCut;
  logic [15:0] wakeIrq, irqEnable;
  logic [2:0]  powerMode;
  logic        cpuClkHalt, periphClkHalt, oscEn, corePwrEn, ramPwrEn, ioHold, wakeRelease;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stbyPowerCtrl i_stbyPowerCtrl (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .stbyEn(stbyEn), .deepEn(deepEn),
    .settleSel(settleSel), .ramCut(ramCut), .wakeNmi(wakeNmi), .wakeIrq(wakeIrq),
    .irqEnable(irqEnable), .powerMode(powerMode), .cpuClkHalt(cpuClkHalt),
    .periphClkHalt(periphClkHalt), .oscEn(oscEn), .corePwrEn(corePwrEn),
    .ramPwrEn(ramPwrEn), .ioHold(ioHold), .wakeRelease(wakeRelease)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; sleepReq = 0; stbyEn = 0; deepEn = 0; wakeNmi = 0;
    settleSel = 0; ramCut = 0; wakeIrq = 0; irqEnable = 16'h00A0;
    cyc(3);
    rstN = 1'b1;
    cyc(2);
  endtask

  task automatic pulseSleep();
    sleepReq = 1'b1;
    cyc(1);
    sleepReq = 1'b0;
  endtask

  task automatic measureSettle(input string req, input int expLen);
    int len = 0;
    int pulses = 0;
    while (powerMode == 3'd3 && len < 70000) begin
      if (!oscEn) chk(req, "oscEn during settling", 0, 1);
      if (wakeRelease) pulses++;
      len++;
      cyc(1);
    end
    chk(req, "settling length", len, expLen);
    chk(req, "release pulses", pulses, 1);
    chk(req, "mode after settling", powerMode, 0);
  endtask

  task automatic t_reset();
    doReset();
    chk("R1", "mode", powerMode, 0);
    chk("R1", "clocks halted", {cpuClkHalt, periphClkHalt}, 0);
    chk("R1", "osc/core/ram", {oscEn, corePwrEn, ramPwrEn}, 7);
    chk("R1", "ioHold/release", {ioHold, wakeRelease}, 0);
  endtask

  task automatic t_sleep();
    doReset();
    pulseSleep();
    chk("R2", "mode", powerMode, 1);
    chk("R2", "cpu/periph halt", {cpuClkHalt, periphClkHalt}, 2);
    chk("R2", "oscEn", oscEn, 1);
    pulseSleep();
    cyc(2);
    chk("R11", "sleepReq in sleep ignored", powerMode, 1);
    // masked line 3 (enable mask 0x00A0)
    wakeIrq[3] = 1'b1;
    cyc(5);
    chk("R3", "masked irq ignored", powerMode, 1);
    wakeIrq[3] = 1'b0;
    // NMI with sync latency
    wakeNmi = 1'b1;
    cyc(1);
    chk("R10", "release after 1 edge", wakeRelease, 0);
    cyc(1);
    chk("R10", "release after 2 edges", wakeRelease, 1);
    cyc(1);
    chk("R3", "release one cycle", wakeRelease, 0);
    chk("R3", "mode after nmi wake", powerMode, 0);
    wakeNmi = 1'b0;
    cyc(3);
    pulseSleep();
    wakeIrq[5] = 1'b1;
    cyc(4);
    chk("R3", "enabled irq wakes", powerMode, 0);
    wakeIrq[5] = 1'b0;
    cyc(3);
  endtask

  task automatic t_deep(input logic [2:0] cut, input int expRam);
    doReset();
    stbyEn = 1; deepEn = 1; ramCut = cut;
    pulseSleep();
    chk("R4", "standby reached first", powerMode, 2);
    cyc(1);
    chk("R5", "deep next cycle", powerMode, 4);
    chk("R8", "clocks halted", {cpuClkHalt, periphClkHalt}, 3);
    chk("R8", "osc/core off, hold", {oscEn, corePwrEn, ioHold}, 1);
    chk("R9", "ram power", ramPwrEn, expRam);
    ramCut = ~cut;
    wakeNmi = 1; wakeIrq = '1;
    cyc(1);
    pulseSleep();
    cyc(5);
    chk("R8", "wake ignored in deep", powerMode, 4);
    chk("R9", "ram code change ignored", ramPwrEn, expRam);
    wakeNmi = 0; wakeIrq = '0;
  endtask

  task automatic t_abort();
    doReset();
    stbyEn = 1; deepEn = 1; settleSel = 0;
    wakeIrq[7] = 1'b1;
    cyc(4);
    pulseSleep();
    chk("R6", "standby entered", powerMode, 2);
    cyc(1);
    chk("R6", "settling instead of deep", powerMode, 3);
    measureSettle("R7", 64);
    wakeIrq[7] = 1'b0;
    cyc(3);
  endtask

  task automatic t_plainStandby(input logic [4:0] sel, input int expLen);
    doReset();
    stbyEn = 1; deepEn = 0; settleSel = sel;
    pulseSleep();
    chk("R4", "standby mode", powerMode, 2);
    cyc(5);
    chk("R4", "stays in standby", powerMode, 2);
    chk("R4", "halt/osc/hold", {cpuClkHalt, periphClkHalt, oscEn, ioHold}, 4'b1101);
    chk("R4", "core/ram on", {corePwrEn, ramPwrEn}, 3);
    pulseSleep();
    chk("R11", "sleepReq in standby ignored", powerMode, 2);
    wakeNmi = 1'b1;
    cyc(3);
    chk("R6", "settling after wake", powerMode, 3);
    measureSettle("R7", expLen);
    wakeNmi = 1'b0;
    cyc(3);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_sleep();
    t_deep(3'b000, 1);
    t_deep(3'b111, 0);
    t_deep(3'b101, 0);
    t_abort();
    t_plainStandby(5'd2, 256);
    t_plainStandby(5'd31, 65535);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule